// File: doc/BRIEF.md
# Software Write Protection Sequencer

This block sits in front of the write path of a byte-wide nonvolatile memory. It watches each qualified write strobe, with its address and data, and looks for two command sequences. A three-write unlock sequence arms protection. When protection is already on, the same sequence instead opens a short window in which real writes are allowed. A six-write sequence removes protection. For every strobe the block decides whether the byte reaches the array (`commit_write`) and whether the external write-cycle timer is started (`start_timer`).

Command writes are never stored. While protection is on, a write that has no unlock in front of it still starts the timer, so the host sees a normal busy period, but nothing is stored. The protection flag has a reset of its own (`cold_rst_n`), which models the as-shipped state. The ordinary reset (`rst_n`) models a power cycle and leaves the flag alone. Consecutive command writes must arrive within `TMO_CYC` clock cycles of each other. That limit is the page-load window.

Top module: `wr_protect_seq`

## Requirements
- R1: After `cold_rst_n` and `rst_n` are released, `protect_on` is 0, and with no strobe both `commit_write` and `start_timer` are 0.
- R2: While unprotected and idle, a strobe that is not a command step drives `commit_write` and `start_timer` to 1 in the same cycle as `wr_stb`. `commit_write` is never 1 without `wr_stb` and `start_timer`.
- R3: The arm/unlock sequence is data 0xAA at address 0x5555, then 0x55 at 0x2AAA, then 0xA0 at 0x5555. None of these writes commits. The third one pulses `start_timer`. `protect_on` rises on the first clock edge at which `timer_busy` is low after having been high at the previous edge, once the sequence has completed.
- R4: While `protect_on` is 1, a write with no unlock in front of it gives `start_timer` = 1 and `commit_write` = 0.
- R5: After an unlock, each write that arrives at most `TMO_CYC` cycles after the previous accepted write commits and restarts the window. A write that arrives later does not commit while protected.
- R6: The disarm sequence is 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, 0x20@0x5555. None of the six commits. Only the sixth pulses `start_timer`. `protect_on` is 0 from the clock edge of the sixth write onwards.
- R7: Asserting `rst_n` alone leaves `protect_on` unchanged and returns the detector to idle.
- R8: A write that does not match the next expected step sends the detector back to idle and is handled as a plain write. Sequence addresses with other data commit normally while unprotected.
- R9: A command write that arrives k cycles after the previous step is accepted when k <= `TMO_CYC`. When k > `TMO_CYC` the detector has already gone back to idle, and the write is handled as a plain write.
- R10: Command matching uses only `wr_addr[14:0]`. Higher address bits are ignored.
- R11: A write accepted as a command step never asserts `commit_write`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the detector and window (power-cycle model) |
| cold_rst_n | input | 1 | Active-low reset of the protection flag (as-shipped state) |
| wr_stb | input | 1 | One-cycle qualified write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data |
| timer_busy | input | 1 | Write-cycle timer running |
| commit_write | output | 1 | Store this byte in the array |
| start_timer | output | 1 | Start the write-cycle timer |
| protect_on | output | 1 | Protection flag |

## Verification
A detector stuck in the wrong step changes `commit_write` on the very next strobe. A lost step makes an authorised data byte vanish, and a missed reset to idle lets a plain write of a command byte vanish. A window counter that is off by one only shows on a write landing exactly `TMO_CYC` or `TMO_CYC`+1 cycles after the previous one, so the bench sweeps the gap across that edge. A flag that sets too early, or that is cleared by `rst_n`, shows on `protect_on` within one cycle of the `timer_busy` fall or of the reset pulse.

// File: rtl/wps_pkg.sv
package wps_pkg;
  localparam int CMP_W = 15;
  localparam logic [CMP_W-1:0] ADR_P = 15'h5555;
  localparam logic [CMP_W-1:0] ADR_Q = 15'h2AAA;
  localparam logic [7:0] BY_1 = 8'hAA;
  localparam logic [7:0] BY_2 = 8'h55;
  localparam logic [7:0] BY_UNL = 8'hA0;
  localparam logic [7:0] BY_DIS = 8'h80;
  localparam logic [7:0] BY_END = 8'h20;

  typedef enum logic [2:0] {
    ST_IDLE, ST_A1, ST_A2, ST_D3, ST_D4, ST_D5, ST_AUTH
  } seq_st_e;

  // does this write match the step expected in state cur
  function automatic logic step_ok(seq_st_e cur, logic [CMP_W-1:0] a, logic [7:0] d);
    case (cur)
      ST_IDLE: step_ok = (a == ADR_P) && (d == BY_1);
      ST_A1:   step_ok = (a == ADR_Q) && (d == BY_2);
      ST_A2:   step_ok = (a == ADR_P) && ((d == BY_UNL) || (d == BY_DIS));
      ST_D3:   step_ok = (a == ADR_P) && (d == BY_1);
      ST_D4:   step_ok = (a == ADR_Q) && (d == BY_2);
      ST_D5:   step_ok = (a == ADR_P) && (d == BY_END);
      default: step_ok = 1'b0;
    endcase
  endfunction

  // state reached after a matching step
  function automatic seq_st_e step_to(seq_st_e cur, logic [7:0] d);
    case (cur)
      ST_IDLE: step_to = ST_A1;
      ST_A1:   step_to = ST_A2;
      ST_A2:   step_to = (d == BY_UNL) ? ST_AUTH : ST_D3;
      ST_D3:   step_to = ST_D4;
      ST_D4:   step_to = ST_D5;
      default: step_to = ST_IDLE;
    endcase
  endfunction
endpackage

// File: rtl/wps_seq_det.sv
module wps_seq_det
  import wps_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_stb,
  input  logic [CMP_W-1:0] cmp_addr,
  input  logic [7:0]       wr_data,
  input  logic             win_expired,
  output logic             seq_active,
  output logic             step_hit,
  output logic             unlock_hit,
  output logic             disable_hit,
  output logic             auth_win
);
  seq_st_e st_q, st_d;

  always_comb begin
    step_hit    = wr_stb && (st_q != ST_AUTH) && step_ok(st_q, cmp_addr, wr_data);
    unlock_hit  = step_hit && (st_q == ST_A2) && (wr_data == BY_UNL);
    disable_hit = step_hit && (st_q == ST_D5);
    auth_win    = (st_q == ST_AUTH);
    seq_active  = (st_q != ST_IDLE);
    st_d = st_q;
    if (wr_stb) begin
      if (st_q == ST_AUTH) st_d = ST_AUTH;
      else if (step_hit)   st_d = step_to(st_q, wr_data);
      else                 st_d = ST_IDLE;
    end else if (win_expired) begin
      st_d = ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end
endmodule

// File: rtl/wps_gap_tmr.sv
module wps_gap_tmr #(
  parameter int TMO_CYC = 37500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(TMO_CYC + 1);
  localparam logic [CW-1:0] LIM = CW'(TMO_CYC);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt_q <= '0;
    else if (restart)            cnt_q <= CW'(1);
    else if (run && cnt_q != LIM) cnt_q <= cnt_q + CW'(1);
  end

  assign expired = run && (cnt_q == LIM);
endmodule

// File: rtl/wps_prot_reg.sv
module wps_prot_reg (
  input  logic clk,
  input  logic cold_rst_n,
  input  logic rst_n,
  input  logic arm,
  input  logic disarm,
  input  logic timer_busy,
  output logic prot_on
);
  logic pend_q, busy_q, cyc_done;

  assign cyc_done = busy_q && !timer_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      busy_q <= timer_busy;
      if (disarm)        pend_q <= 1'b0;
      else if (arm)      pend_q <= 1'b1;
      else if (cyc_done) pend_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge cold_rst_n) begin
    if (!cold_rst_n)             prot_on <= 1'b0;
    else if (disarm)             prot_on <= 1'b0;
    else if (pend_q && cyc_done) prot_on <= 1'b1;
  end
endmodule

// File: rtl/wr_protect_seq.sv
module wr_protect_seq
  import wps_pkg::*;
#(
  parameter int ADDR_W  = 17,
  parameter int TMO_CYC = 37500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cold_rst_n,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              timer_busy,
  output logic              commit_write,
  output logic              start_timer,
  output logic              protect_on
);
  logic seq_active, step_hit, unlock_hit, disable_hit, auth_win;
  logic win_expired, plain_wr;

  generate
    if (ADDR_W > CMP_W) begin : g_hi
      logic addr_hi_unused;
      assign addr_hi_unused = ^wr_addr[ADDR_W-1:CMP_W];
    end
  endgenerate

  wps_seq_det u_det (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb),
    .cmp_addr(wr_addr[CMP_W-1:0]), .wr_data(wr_data),
    .win_expired(win_expired), .seq_active(seq_active),
    .step_hit(step_hit), .unlock_hit(unlock_hit),
    .disable_hit(disable_hit), .auth_win(auth_win)
  );

  wps_gap_tmr #(.TMO_CYC(TMO_CYC)) u_gap (
    .clk(clk), .rst_n(rst_n),
    .restart(step_hit || (wr_stb && auth_win)),
    .run(seq_active), .expired(win_expired)
  );

  wps_prot_reg u_flag (
    .clk(clk), .cold_rst_n(cold_rst_n), .rst_n(rst_n),
    .arm(unlock_hit), .disarm(disable_hit),
    .timer_busy(timer_busy), .prot_on(protect_on)
  );

  assign plain_wr     = wr_stb && !step_hit;
  assign commit_write = plain_wr && (auth_win || !protect_on);
  assign start_timer  = plain_wr || unlock_hit || disable_hit;
endmodule

// File: rtl/wr_protect_seq_chk.sv
module wr_protect_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic cold_rst_n,
  input logic wr_stb,
  input logic timer_busy,
  input logic commit_write,
  input logic start_timer,
  input logic protect_on,
  input logic step_hit,
  input logic disable_hit,
  input logic auth_win
);
  p_step_nocommit_r11: assert property (@(posedge clk) disable iff (!rst_n || !cold_rst_n)
    step_hit |-> !commit_write);
  p_commit_start_r2: assert property (@(posedge clk) disable iff (!rst_n || !cold_rst_n)
    commit_write |-> (start_timer && wr_stb));
  p_prot_rise_r3: assert property (@(posedge clk) disable iff (!rst_n || !cold_rst_n)
    $rose(protect_on) |-> ($past(timer_busy, 2) && !$past(timer_busy)));
  p_unauth_r4: assert property (@(posedge clk) disable iff (!rst_n || !cold_rst_n)
    (commit_write && protect_on) |-> auth_win);
  p_disable_clear_r6: assert property (@(posedge clk) disable iff (!rst_n || !cold_rst_n)
    disable_hit |=> !protect_on);
  p_prot_fall_r6: assert property (@(posedge clk) disable iff (!rst_n || !cold_rst_n)
    $fell(protect_on) |-> $past(disable_hit));
endmodule

bind wr_protect_seq wr_protect_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cold_rst_n(cold_rst_n), .wr_stb(wr_stb),
  .timer_busy(timer_busy), .commit_write(commit_write),
  .start_timer(start_timer), .protect_on(protect_on),
  .step_hit(step_hit), .disable_hit(disable_hit), .auth_win(auth_win)
);

// File: tb/sim_wr_protect_seq.sv
module sim_wr_protect_seq;
  localparam int AW  = 17;
  localparam int TMO = 16;

  logic clk = 1'b0, rst_n = 1'b0, cold_rst_n = 1'b0;
  logic wr_stb = 1'b0, timer_busy = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic commit_write, start_timer, protect_on;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  wr_protect_seq #(.ADDR_W(AW), .TMO_CYC(TMO)) u0 (
    .clk(clk), .rst_n(rst_n), .cold_rst_n(cold_rst_n), .wr_stb(wr_stb),
    .wr_addr(wr_addr), .wr_data(wr_data), .timer_busy(timer_busy),
    .commit_write(commit_write), .start_timer(start_timer), .protect_on(protect_on)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one strobe; checks {commit,start} before the edge
  task automatic wrx(input logic [AW-1:0] a, input logic [7:0] d,
                     input logic ec, input logic es, input string tag);
    wr_stb = 1'b1; wr_addr = a; wr_data = d;
    #1;
    chk(tag, {commit_write, start_timer}, {ec, es});
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic unlock(input string tag);
    wrx(17'h05555, 8'hAA, 1'b0, 1'b0, tag);
    wrx(17'h02AAA, 8'h55, 1'b0, 1'b0, tag);
    wrx(17'h05555, 8'hA0, 1'b0, 1'b1, tag);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    cold_rst_n = 1'b1; rst_n = 1'b1;
    idle(2);
    // R1 reset state
    chk("R1 protect after reset", protect_on, 1'b0);
    chk("R1 outputs idle", {commit_write, start_timer}, 2'b00);

    // R2/R8: every data value to a sequence address while unprotected
    for (int d = 0; d < 256; d++) begin
      wrx(17'h05555, 8'(d), (d != 8'hAA), (d != 8'hAA), "R2 R8 data sweep");
      idle(TMO + 2);
    end
    wrx(17'h00123, 8'h5A, 1'b1, 1'b1, "R2 plain write");

    // R10/R3: arm with upper address bits set
    wrx(17'h1D555, 8'hAA, 1'b0, 1'b0, "R10 step1");
    wrx(17'h0AAAA, 8'h55, 1'b0, 1'b0, "R10 step2");
    wrx(17'h15555, 8'hA0, 1'b0, 1'b1, "R3 R11 step3 timer");
    timer_busy = 1'b1;
    idle(3);
    chk("R3 no protect while busy", protect_on, 1'b0);
    timer_busy = 1'b0;
    #1; chk("R3 no protect before edge", protect_on, 1'b0);
    @(negedge clk);
    chk("R3 protect after cycle", protect_on, 1'b1);
    idle(TMO + 2);

    // R4 unauthorised writes
    for (int i = 0; i < 4; i++)
      wrx(17'(i * 17'h3011), 8'(i + 3), 1'b0, 1'b1, "R4 unauthorised");

    // R5 window after unlock, gap sweep
    for (int k = 1; k <= TMO + 3; k++) begin
      unlock("R5 unlock");
      idle(k - 1);
      wrx(17'h00200, 8'h11, (k <= TMO), 1'b1, "R5 window gap");
      idle(TMO + 2);
    end
    unlock("R5 page unlock");
    for (int i = 0; i < 4; i++) wrx(17'(16'h0300 + i), 8'(i), 1'b1, 1'b1, "R5 page bytes");
    idle(TMO + 2);

    // R9 gap between command writes
    for (int k = 1; k <= TMO + 3; k++) begin
      wrx(17'h05555, 8'hAA, 1'b0, (k == 0), "R9 first step");
      idle(k - 1);
      wrx(17'h02AAA, 8'h55, 1'b0, (k > TMO), "R9 second after gap");
      wrx(17'h05555, 8'hA0, 1'b0, 1'b1, "R9 third");
      wrx(17'h00400, 8'h77, (k <= TMO), 1'b1, "R9 data");
      idle(TMO + 2);
    end

    // R8 mismatch while protected
    wrx(17'h05555, 8'hAA, 1'b0, 1'b0, "R8 step1");
    wrx(17'h02AAA, 8'h56, 1'b0, 1'b1, "R8 mismatch");
    wrx(17'h05555, 8'hA0, 1'b0, 1'b1, "R8 orphan third");
    wrx(17'h00500, 8'h99, 1'b0, 1'b1, "R8 data after mismatch");

    // R7 plain reset keeps flag, clears detector
    unlock("R7 unlock");
    rst_n = 1'b0; idle(2); rst_n = 1'b1; idle(1);
    chk("R7 flag kept", protect_on, 1'b1);
    wrx(17'h00600, 8'h42, 1'b0, 1'b1, "R7 window closed");

    // R6 disarm
    wrx(17'h05555, 8'hAA, 1'b0, 1'b0, "R6 d1");
    wrx(17'h02AAA, 8'h55, 1'b0, 1'b0, "R6 d2");
    wrx(17'h05555, 8'h80, 1'b0, 1'b0, "R6 d3");
    wrx(17'h05555, 8'hAA, 1'b0, 1'b0, "R6 d4");
    wrx(17'h02AAA, 8'h55, 1'b0, 1'b0, "R6 d5");
    chk("R6 still protected", protect_on, 1'b1);
    wrx(17'h05555, 8'h20, 1'b0, 1'b1, "R6 d6");
    chk("R6 protect cleared", protect_on, 1'b0);
    wrx(17'h05555, 8'h33, 1'b1, 1'b1, "R8 sequence address writable");
    wrx(17'h02AAA, 8'h55, 1'b1, 1'b1, "R8 second address writable");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule